// File: doc/BRIEF.md
# Quad-I/O Flash Erase Sequencer

This block erases a serial NOR flash that is already in four-line command mode. It can erase either one 4 KiB sector or the whole array. A host sets the operation kind and a 24-bit address, then pulses `start`. The block then runs three chip-select frames in turn: a write-enable frame, the erase frame and a status frame. In the status frame it reads the device status over and over until the busy bit clears. Every byte on the bus is carried as two nibbles on four data lines. The block drives chip select, the serial clock and the data lines, and it owns the direction control of the data lines.

The serial clock runs at half the block clock. In each nibble the clock is low for one cycle and high for one cycle. Between frames, chip select stays high for a number of cycles derived from the clock period and the device's minimum deselect time. When the erase frame closes, a timeout counter starts. If the device is still busy when the limit is reached, the status frame is cut short and the error flag is raised instead of `done`. The busy-bit position is a parameter, because devices differ on where that flag sits in the status byte.

Top module: `qerase_seq`

## Requirements
- R1: After reset and whenever `busy` is low, `cs_n` is 1, `sck` is 0 and `sio_oe` is 0.
- R2: Each byte goes out as two nibbles on `sio_out[3:0]`, upper nibble first. There is one rising edge of `sck` per nibble, and the data are stable while `sck` is high.
- R3: Each operation starts with a frame of its own that holds only the byte 0x06. Chip select goes high at the end of that frame, before the erase frame begins.
- R4: With `chip_mode`=0, the erase frame is byte 0x20 followed by the three bytes of `addr`, most significant byte first.
- R5: With `chip_mode`=1, the erase frame is the single byte 0xC7, with no address.
- R6: The status frame sends byte 0x05 and then reads status bytes in the same frame. Each read byte is built from two nibbles sampled while `sck` is high, upper nibble first. The frame closes after the first byte whose bit BUSY_BIT (default 0) is 0, so the device sees exactly one idle byte.
- R7: Chip select stays high for at least ceil(TCSH_NS/CLK_NS) clock cycles (7 by default) between any two frames, including the gap from one operation to the next.
- R8: After the last nibble of 0x05, `sio_oe` falls while `sck` is still high, and `sck` falls one cycle later.
- R9: On a normal finish, `done` is high for exactly one cycle, and `busy` goes low on that same edge.
- R10: If the device is still busy TMO_US microseconds after the erase frame closes, the status frame is aborted and chip select goes high. `timeout_err` is then set and `done` does not pulse.
- R11: A `start` pulse while `busy` is high is ignored. It produces no frames and leaves the operation in progress unchanged.
- R12: `timeout_err` holds its value until the next accepted `start`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an erase |
| chip_mode | input | 1 | 1 = whole-chip erase, 0 = sector erase |
| addr | input | AW | Sector address, sampled at start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse on normal finish |
| timeout_err | output | 1 | Erase exceeded its time limit |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock to flash |
| sio_out | output | 4 | Data driven to the quad lines |
| sio_oe | output | 1 | Output enable for the quad lines |
| sio_in | input | 4 | Data read from the quad lines |

## Verification
The hardest cases to reach are the timeout path and the bus turnaround inside the status frame, because both depend on how long the flash stays busy. The bench contains a small flash model that answers each status read with a programmed number of busy bytes and then one idle byte. Setting that count far above the limit, with a short TMO_US override, drives the block into the abort path. The busy value also has its upper bits set and the idle value has all bits but bit 0 set, so a design that tests the wrong bit either stops early or polls until it times out.

// File: rtl/qerase_pkg.sv
package qerase_pkg;
  typedef enum logic [2:0] {S_IDLE, S_TX, S_TURN, S_RX, S_GAP} qe_state_t;
  typedef enum logic [1:0] {F_WREN, F_ERASE, F_POLL, F_END} qe_frame_t;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_SECTOR = 8'h20;
  localparam logic [7:0] OP_CHIP   = 8'hC7;
  localparam logic [7:0] OP_STATUS = 8'h05;
endpackage

// File: rtl/qerase_cnt.sv
module qerase_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else            q <= q + 1'b1;
  end
endmodule

// File: rtl/qerase_seq.sv
module qerase_seq
  import qerase_pkg::*;
#(
  parameter int CLK_NS   = 8,
  parameter int TCSH_NS  = 50,
  parameter int TMO_US   = 400000,
  parameter int AW       = 24,
  parameter int BUSY_BIT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          chip_mode,
  input  logic [AW-1:0] addr,
  output logic          busy,
  output logic          done,
  output logic          timeout_err,
  output logic          cs_n,
  output logic          sck,
  output logic [3:0]    sio_out,
  output logic          sio_oe,
  input  logic [3:0]    sio_in
);
  localparam int GAP_RAW = (TCSH_NS + CLK_NS - 1) / CLK_NS;
  localparam int GAP_CYC = (GAP_RAW < 2) ? 2 : GAP_RAW;
  localparam int GW      = $clog2(GAP_CYC + 1);
  localparam longint TMO_L = (longint'(TMO_US) * 1000) / CLK_NS;
  localparam int TMO_CYC = int'(TMO_L);
  localparam int TW      = $clog2(TMO_CYC + 1);
  localparam int SW      = 8 + AW;
  localparam int MAXNIB  = 2 + AW / 4;
  localparam int NW      = $clog2(MAXNIB + 1);

  qe_state_t st;
  qe_frame_t fr, nf;
  logic [SW-1:0] sh, open_w;
  logic [NW-1:0] nib_left, open_n;
  logic          ph, lo, tmo_run, tmo_hit, chip_q;
  logic [AW-1:0] addr_q;
  logic [3:0]    hi_nib;
  logic [7:0]    stat_w;
  logic [GW-1:0] gcnt;
  logic [TW-1:0] tcnt;
  logic          gap_end, open_now, tmo_fire;

  qerase_cnt #(.W(GW)) u_gap (.clk(clk), .rst(rst), .clr(st != S_GAP), .q(gcnt));
  qerase_cnt #(.W(TW)) u_tmo (.clk(clk), .rst(rst), .clr(!tmo_run),   .q(tcnt));

  assign stat_w   = {hi_nib, sio_in};
  assign gap_end  = (st == S_GAP) && (gcnt == GW'(GAP_CYC - 1));
  assign open_now = ((st == S_IDLE) && start) || (gap_end && fr != F_END);
  assign tmo_fire = tmo_run && (tcnt == TW'(TMO_CYC - 1));

  always_comb begin
    nf = F_WREN;
    if (st == S_GAP) nf = (fr == F_WREN) ? F_ERASE : F_POLL;
    open_n = NW'(2);
    case (nf)
      F_WREN:  open_w = {OP_WREN, {AW{1'b0}}};
      F_ERASE: begin
        if (chip_q) open_w = {OP_CHIP, {AW{1'b0}}};
        else begin
          open_w = {OP_SECTOR, addr_q};
          open_n = NW'(MAXNIB);
        end
      end
      default: open_w = {OP_STATUS, {AW{1'b0}}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; fr <= F_END; sh <= '0; nib_left <= '0;
      ph <= 1'b0; lo <= 1'b0; hi_nib <= '0; tmo_run <= 1'b0; tmo_hit <= 1'b0;
      chip_q <= 1'b0; addr_q <= '0; busy <= 1'b0; done <= 1'b0; timeout_err <= 1'b0;
      cs_n <= 1'b1; sck <= 1'b0; sio_out <= '0; sio_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          busy <= 1'b1; timeout_err <= 1'b0; tmo_hit <= 1'b0;
          chip_q <= chip_mode; addr_q <= addr;
        end
        S_TX: begin
          if (!ph) begin
            sck <= 1'b1; ph <= 1'b1;
          end else if (nib_left == NW'(1)) begin
            sio_oe <= 1'b0;
            if (fr == F_POLL) st <= S_TURN;
            else begin
              cs_n <= 1'b1; sck <= 1'b0; st <= S_GAP;
              if (fr == F_ERASE) tmo_run <= 1'b1;
            end
          end else begin
            sck <= 1'b0; ph <= 1'b0;
            sio_out <= sh[SW-5 -: 4];
            sh <= sh << 4;
            nib_left <= nib_left - 1'b1;
          end
        end
        S_TURN: begin
          sck <= 1'b0; ph <= 1'b0; lo <= 1'b0; st <= S_RX;
        end
        S_RX: begin
          if (!ph) begin
            sck <= 1'b1; ph <= 1'b1;
          end else begin
            sck <= 1'b0; ph <= 1'b0;
            if (!lo) begin
              hi_nib <= sio_in; lo <= 1'b1;
            end else begin
              lo <= 1'b0;
              if (!stat_w[BUSY_BIT]) begin
                cs_n <= 1'b1; tmo_run <= 1'b0; fr <= F_END; st <= S_GAP;
              end
            end
          end
        end
        S_GAP: if (gap_end && fr == F_END) begin
          busy <= 1'b0; done <= !tmo_hit; timeout_err <= tmo_hit; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (open_now) begin
        fr <= nf; sh <= open_w; sio_out <= open_w[SW-1 -: 4]; nib_left <= open_n;
        cs_n <= 1'b0; sck <= 1'b0; sio_oe <= 1'b1; ph <= 1'b0; st <= S_TX;
      end
      if (tmo_fire) begin
        cs_n <= 1'b1; sck <= 1'b0; sio_oe <= 1'b0; tmo_run <= 1'b0;
        tmo_hit <= 1'b1; fr <= F_END; st <= S_GAP;
      end
    end
  end

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n && !sck && !sio_oe));
  // R2
  nib_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sck && sio_oe) |-> $stable(sio_out));
  // R7
  deselect_min_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |=> cs_n);
  // R8
  turn_high_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sio_oe) |-> (sck || cs_n));
  // R9
  done_one_cyc_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10
  tmo_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_err) |-> !done);
  // R11
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(addr_q));
endmodule

// File: tb/sim_qerase_seq.sv
module sim_qerase_seq;
  localparam int CLK_NS  = 8;
  localparam int GAP_EXP = (50 + CLK_NS - 1) / CLK_NS;
  localparam logic [7:0] BUSY_V = 8'h81;
  localparam logic [7:0] IDLE_V = 8'hFE;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, chip_mode = 1'b0;
  logic [23:0] addr = '0;
  logic busy, done, timeout_err, cs_n, sck, sio_oe;
  logic [3:0] sio_out, sio_in;

  int errors = 0, checks = 0;
  logic [35:0] expq[$];
  logic [31:0] cap;
  int ncap, rx_nib, rx_bytes, busy_bytes, done_cnt, hi_run;
  bit in_frame, turn_checked, abort_exp, prev_done, prev_cs;
  logic [7:0] v;

  always #(CLK_NS/2) clk = ~clk;

  qerase_seq #(.CLK_NS(CLK_NS), .TMO_US(3)) u0 (
    .clk(clk), .rst(rst), .start(start), .chip_mode(chip_mode), .addr(addr),
    .busy(busy), .done(done), .timeout_err(timeout_err), .cs_n(cs_n), .sck(sck),
    .sio_out(sio_out), .sio_oe(sio_oe), .sio_in(sio_in));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial sio_in = '0;

  // flash model: frame capture
  always @(negedge cs_n) begin
    cap = '0; ncap = 0; rx_nib = 0; rx_bytes = 0; in_frame = 1; turn_checked = 0;
  end

  always @(posedge sck) begin
    if (sio_oe) begin
      cap = {cap[27:0], sio_out}; ncap++;
    end else begin
      v = (rx_bytes < busy_bytes) ? BUSY_V : IDLE_V;
      #1;
      sio_in = (rx_nib % 2 == 0) ? v[7:4] : v[3:0];
      if (rx_nib % 2 == 1) rx_bytes++;
      rx_nib++;
    end
  end

  always @(negedge sck) begin
    if (!turn_checked && ncap == 2 && cap == 32'h05) begin
      turn_checked = 1;
      // R8: lines released before the falling clock
      chk(sio_oe == 1'b0, "R8 turnaround", sio_oe, 0);
    end
  end

  // scoreboard monitor
  always @(posedge cs_n) begin
    if (in_frame) begin
      logic [35:0] exp_i;
      in_frame = 0;
      if (expq.size() == 0) begin
        chk(0, "R11 unexpected frame", {4'(ncap), cap}, 0);
      end else begin
        exp_i = expq.pop_front();
        // R2 R3 R4 R5: nibble order and frame contents
        chk({4'(ncap), cap} == exp_i, "R2/R3/R4/R5 frame", {4'(ncap), cap}, exp_i);
        if (exp_i == {4'd2, 32'h05} && !abort_exp)
          chk(rx_bytes == busy_bytes + 1, "R6 status reads", rx_bytes, busy_bytes + 1);
      end
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      hi_run = 100; prev_done = 0; prev_cs = 1;
    end else begin
      if (done) begin
        done_cnt++;
        chk(!prev_done, "R9 done width", 1, 0);
        chk(!busy, "R9 busy with done", busy, 0);
      end
      if (!cs_n && prev_cs)
        chk(hi_run >= GAP_EXP, "R7 deselect", hi_run, GAP_EXP);
      hi_run = cs_n ? hi_run + 1 : 0;
      prev_done = done; prev_cs = cs_n;
    end
  end

  task automatic check_idle(input string tag);
    chk(cs_n === 1'b1, {tag, " R1 cs_n"}, cs_n, 1);
    chk(sck === 1'b0, {tag, " R1 sck"}, sck, 0);
    chk(sio_oe === 1'b0, {tag, " R1 oe"}, sio_oe, 0);
    chk(busy === 1'b0, {tag, " R1 busy"}, busy, 0);
  endtask

  task automatic run_op(input bit chip, input logic [23:0] a, input int nbusy,
                        input bit to_exp, input bit poke);
    expq.push_back({4'd2, 32'h06});
    if (chip) expq.push_back({4'd2, 32'hC7});
    else      expq.push_back({4'd8, 8'h20, a});
    expq.push_back({4'd2, 32'h05});
    busy_bytes = nbusy; abort_exp = to_exp; done_cnt = 0;
    @(negedge clk); start = 1; chip_mode = chip; addr = a;
    @(negedge clk); start = 0;
    // R12
    chk(timeout_err == 1'b0, "R12 err cleared on start", timeout_err, 0);
    if (poke) begin
      repeat (12) @(negedge clk);
      start = 1; chip_mode = ~chip; addr = ~a;
      @(negedge clk); start = 0;
    end
    for (int i = 0; i < 5000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    chk(done_cnt == (to_exp ? 0 : 1), "R9/R10 done count", done_cnt, to_exp ? 0 : 1);
    chk(timeout_err == to_exp, "R10 timeout flag", timeout_err, to_exp);
    chk(expq.size() == 0, "R3 frames missing", expq.size(), 0);
    check_idle("post-op");
  endtask

  initial begin
    #(CLK_NS * 150000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    busy_bytes = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_idle("reset");
    run_op(0, 24'h123456, 3, 0, 0);
    run_op(1, 24'h000000, 0, 0, 0);
    run_op(0, 24'hFEDCBA, 5, 0, 1);   // R11: start while busy
    run_op(0, 24'h00F000, 1000, 1, 0); // R10: device never idle
    repeat (3) @(negedge clk);
    chk(timeout_err == 1'b1, "R12 err held", timeout_err, 1);
    run_op(1, 24'h0, 2, 0, 0);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule